// File: doc/BRIEF.md
# Coprocessor Pipeline Tracker with Busy-Wait Handshake

This block sits on the coprocessor side of a tightly coupled link to a three-stage fetch/decode/execute processor core. Each time the core fetches, the block takes the 32-bit word from the shared instruction bus and moves it through its own three-entry copy of the core's pipeline. The block therefore always holds the word that the core is executing. When the core pulls its active-low request strobe low, it is asking whether the coprocessor accepts the execute-stage word. The block replies on two lines: `cop_absent` says whether this unit owns the instruction, and `cop_busy` makes the core stall until the operation can start.

The wait length comes from a programmable countdown. A stub stands in for the real datapath and loads this countdown from `wait_cycles` each time a new word enters execute. An interrupt can make the core withdraw a stalled instruction by raising the strobe before busy is released. In that case the block drops the instruction with no side effect and keeps following the pipeline. For checking, a committed instruction produces a one-cycle accept strobe carrying the word, and a dropped one produces a one-cycle abandon strobe and increments a counter.

Top module: `cpt_handshake`

## Requirements
- R1: On each clock edge with `instr_fetch` high, the word on `instr_bus` enters the mirror, and every held word moves one stage on. A word reaches execute on the third such edge, so words commit in fetch order.
- R2: `cop_absent` is low only when the execute word is a coprocessor instruction for this unit. That means bits [27:24] equal 4'b1110, or bits [27:25] equal 3'b110, and bits [11:8] equal the parameter `CP_ID` (default 5). For any other word, `cop_absent` is high.
- R3: The edge that moves a word into execute loads `wait_cycles` as N. For an owned word, `cop_busy` is then high for exactly N clock cycles in which the strobe is low, and low afterwards.
- R4: On an edge where `cop_req_n` is low and both `cop_absent` and `cop_busy` are low, the instruction commits. `accept_stb` is high for the following cycle, with `accept_word` equal to that word.
- R5: Suppose the strobe has been low for the current owned instruction and the instruction has not committed. If the strobe is then high on an edge, `abandon_stb` is high for the following cycle and `abandon_count` increments by one. No accept follows for that instruction.
- R6: After an abandon, later instructions are tracked, waited and committed normally.
- R7: While `rst_n` is low at a clock edge, the block is cleared. After that edge, `cop_absent` is high, `cop_busy` is low, both strobes are low and `abandon_count` is 0. The mirror holds non-coprocessor words, so a low strobe gives no commit.
- R8: While the strobe stays high before engagement, the countdown does not run and no strobe is raised.
- R9: If an abandon and a fetch fall on the same edge, both take effect. The abandon strobe fires, and the mirror shifts.
- R10: An instruction commits at most once, even if the strobe stays low after commit.
- R11: A non-owned word in execute never raises `cop_busy` and never produces accept or abandon, whatever the strobe does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_fetch | input | 1 | High on the edges where the core fetches and its pipeline advances |
| instr_bus | input | 32 | Instruction word on the shared data bus |
| cop_req_n | input | 1 | Active-low strobe: a coprocessor or undefined word is in execute |
| wait_cycles | input | WAIT_W | Busy-wait length loaded when a word enters execute |
| cop_absent | output | 1 | High when this unit does not own the execute word |
| cop_busy | output | 1 | High while the unit cannot yet accept the instruction |
| accept_stb | output | 1 | One-cycle strobe after a commit |
| accept_word | output | 32 | Word committed by the last accept |
| abandon_stb | output | 1 | One-cycle strobe after an abandoned instruction |
| abandon_count | output | CNT_W | Number of abandoned instructions, wrapping |

## Verification
Two of the block's functions can fall in the same cycle. One is the core withdrawing a stalled instruction for an interrupt. The other is the core advancing its pipeline to fetch the handler. To provoke this, the bench raises the strobe and pulses `instr_fetch` at one edge while busy is still high. It then judges the result on three points. The abandon strobe and the count step must both appear. The mirror must hold the shifted words. The word fetched in that same cycle must later reach execute and commit with the correct data.

// File: rtl/cpt_pkg.sv
// Shared definitions for the coprocessor pipeline tracker.
// Assumes the instruction class is coded in bits [27:24] of the word.
package cpt_pkg;

    localparam int unsigned WORD_W = 32;

    // Word loaded into the mirror by reset; its class field is not a coprocessor class.
    localparam logic [WORD_W-1:0] IDLE_WORD = '0;

    // True for the coprocessor data/register-transfer class or the load/store class.
    function automatic logic is_cop_class(input logic [3:0] cls);
        return (cls == 4'b1110) || (cls[3:1] == 3'b110);
    endfunction

endpackage

// File: rtl/cpt_pipe_mirror.sv
// Mirror of the core's fetch/decode/execute pipeline.
// Assumes the core advances every stage together on an edge with advance high.
module cpt_pipe_mirror
    import cpt_pkg::*;
#(
    parameter int unsigned DEPTH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic [WORD_W-1:0] bus_word,
    output logic [WORD_W-1:0] exec_word
);

    logic [WORD_W-1:0] stage_q [DEPTH];

    // Entry stage captures the bus word on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q[0] <= IDLE_WORD;
        else if (advance)
            stage_q[0] <= bus_word;
    end

    for (genvar s = 1; s < DEPTH; s++) begin : g_stage
        // Each later stage takes its neighbour's word on each advance.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage_q[s] <= IDLE_WORD;
            else if (advance)
                stage_q[s] <= stage_q[s-1];
        end
    end

    assign exec_word = stage_q[DEPTH-1];

endmodule

// File: rtl/cpt_owner_decode.sv
// Decides whether the execute-stage word belongs to this coprocessor.
// Assumes class bits and coprocessor-number bits are passed in as slices.
module cpt_owner_decode
    import cpt_pkg::*;
#(
    parameter logic [3:0] CP_ID = 4'd5
) (
    input  logic [3:0] class_bits,
    input  logic [3:0] cp_field,
    output logic       owned
);

    // Ownership: coprocessor class and matching unit number.
    always_comb owned = is_cop_class(class_bits) && (cp_field == CP_ID);

endmodule

// File: rtl/cpt_wait_ctrl.sv
// Busy-wait countdown, commit and abandon control.
// Assumes the core stalls while busy is high and never advances with the strobe low
// except on the commit edge.
module cpt_wait_ctrl
    import cpt_pkg::*;
#(
    parameter int unsigned WAIT_W = 8,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              owned,
    input  logic              req_n,
    input  logic [WAIT_W-1:0] wait_load,
    input  logic [WORD_W-1:0] exec_word,
    output logic              busy,
    output logic              accept_stb,
    output logic [WORD_W-1:0] accept_word,
    output logic              abandon_stb,
    output logic [CNT_W-1:0]  abandon_count
);

    logic [WAIT_W-1:0] remain_q;
    logic              closed_q;   // instruction already committed or abandoned
    logic              engaged_q;  // strobe seen low for the current instruction
    logic              live;
    logic              do_commit;
    logic              do_abandon;
    logic              do_count;

    // Event decode from current state and strobe.
    always_comb begin
        live       = owned && !closed_q;
        busy       = live && (remain_q != '0);
        do_commit  = live && !req_n && (remain_q == '0);
        do_count   = live && !req_n && (remain_q != '0);
        do_abandon = live && req_n && engaged_q;
    end

    // Countdown and per-instruction flags; a new execute word restarts them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q  <= '0;
            closed_q  <= 1'b0;
            engaged_q <= 1'b0;
        end else if (advance) begin
            remain_q  <= wait_load;
            closed_q  <= 1'b0;
            engaged_q <= 1'b0;
        end else begin
            if (do_count)
                remain_q <= remain_q - 1'b1;
            if (do_commit || do_abandon) begin
                closed_q  <= 1'b1;
                engaged_q <= 1'b0;
            end else if (live && !req_n) begin
                engaged_q <= 1'b1;
            end
        end
    end

    // Outcome strobes, committed word and abandon tally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_stb    <= 1'b0;
            accept_word   <= '0;
            abandon_stb   <= 1'b0;
            abandon_count <= '0;
        end else begin
            accept_stb  <= do_commit;
            abandon_stb <= do_abandon;
            if (do_commit)
                accept_word <= exec_word;
            if (do_abandon)
                abandon_count <= abandon_count + 1'b1;
        end
    end

endmodule

// File: rtl/cpt_handshake.sv
// Coprocessor side of the busy-wait handshake with a three-stage core.
// Assumes a synchronous active-low reset and the core's active-low request strobe.
module cpt_handshake
    import cpt_pkg::*;
#(
    parameter logic [3:0]  CP_ID  = 4'd5,
    parameter int unsigned WAIT_W = 8,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_fetch,
    input  logic [31:0]       instr_bus,
    input  logic              cop_req_n,
    input  logic [WAIT_W-1:0] wait_cycles,
    output logic              cop_absent,
    output logic              cop_busy,
    output logic              accept_stb,
    output logic [31:0]       accept_word,
    output logic              abandon_stb,
    output logic [CNT_W-1:0]  abandon_count
);

    logic [WORD_W-1:0] exec_word;
    logic              owned;

    cpt_pipe_mirror #(.DEPTH(DEPTH)) u_mirror (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (instr_fetch),
        .bus_word  (instr_bus),
        .exec_word (exec_word)
    );

    cpt_owner_decode #(.CP_ID(CP_ID)) u_decode (
        .class_bits (exec_word[27:24]),
        .cp_field   (exec_word[11:8]),
        .owned      (owned)
    );

    cpt_wait_ctrl #(.WAIT_W(WAIT_W), .CNT_W(CNT_W)) u_wait (
        .clk           (clk),
        .rst_n         (rst_n),
        .advance       (instr_fetch),
        .owned         (owned),
        .req_n         (cop_req_n),
        .wait_load     (wait_cycles),
        .exec_word     (exec_word),
        .busy          (cop_busy),
        .accept_stb    (accept_stb),
        .accept_word   (accept_word),
        .abandon_stb   (abandon_stb),
        .abandon_count (abandon_count)
    );

    // Response: absent unless this unit owns the execute word.
    always_comb cop_absent = !owned;

endmodule

// File: rtl/cpt_handshake_chk.sv
// Protocol checker bound to cpt_handshake; observes ports only.
module cpt_handshake_chk #(
    parameter int unsigned WAIT_W = 8,
    parameter int unsigned CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_fetch,
    input logic [31:0]       instr_bus,
    input logic              cop_req_n,
    input logic [WAIT_W-1:0] wait_cycles,
    input logic              cop_absent,
    input logic              cop_busy,
    input logic              accept_stb,
    input logic [31:0]       accept_word,
    input logic              abandon_stb,
    input logic [CNT_W-1:0]  abandon_count
);

    // Busy may only be raised for an owned instruction.
    assert_busy_owned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cop_busy |-> !cop_absent);

    // Accept follows an edge with strobe low, present and not busy.
    assert_accept_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept_stb |-> $past(!cop_req_n && !cop_absent && !cop_busy));

    // Abandon follows an edge where the strobe was high for an owned word.
    assert_abandon_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        abandon_stb |-> $past(cop_req_n && !cop_absent));

    // One instruction never yields both outcomes at once.
    assert_single_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept_stb && abandon_stb));

    // Tally moves only together with an abandon strobe.
    assert_tally_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (abandon_count != $past(abandon_count)) |-> abandon_stb);

endmodule

bind cpt_handshake cpt_handshake_chk #(.WAIT_W(WAIT_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/cpt_handshake_bench.sv
module cpt_handshake_bench;

    localparam logic [31:0] CDP5  = 32'hEE000500;
    localparam logic [31:0] CDP5B = 32'hEE100510;
    localparam logic [31:0] LDC5  = 32'hED900500;
    localparam logic [31:0] CDP3  = 32'hEE000300;
    localparam logic [31:0] ADD5  = 32'hE0800500;
    localparam logic [31:0] NOP   = 32'hE1A00000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_fetch = 1'b0;
    logic [31:0] instr_bus = '0;
    logic        cop_req_n = 1'b1;
    logic [7:0]  wait_cycles = '0;
    logic        cop_absent, cop_busy, accept_stb, abandon_stb;
    logic [31:0] accept_word;
    logic [7:0]  abandon_count;

    int checks = 0;
    int fails  = 0;
    int exp_count = 0;
    bit ended = 1'b0;

    always #4 clk = ~clk;

    cpt_handshake u_cpt_handshake (
        .clk(clk), .rst_n(rst_n), .instr_fetch(instr_fetch), .instr_bus(instr_bus),
        .cop_req_n(cop_req_n), .wait_cycles(wait_cycles), .cop_absent(cop_absent),
        .cop_busy(cop_busy), .accept_stb(accept_stb), .accept_word(accept_word),
        .abandon_stb(abandon_stb), .abandon_count(abandon_count)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic push(input logic [31:0] w);
        instr_fetch = 1'b1;
        instr_bus   = w;
        step();
        instr_fetch = 1'b0;
        instr_bus   = '0;
    endtask

    task automatic fill(input logic [31:0] w);
        push(w); push(NOP); push(NOP);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R7 absent", cop_absent, 1);
        chk("R7 busy", cop_busy, 0);
        chk("R7 accept", accept_stb, 0);
        chk("R7 abandon", abandon_stb, 0);
        chk("R7 count", abandon_count, 0);
        cop_req_n = 1'b0;
        step(); step();
        chk("R7 no commit from idle mirror", accept_stb, 0);
        chk("R7 absent stays", cop_absent, 1);
        cop_req_n = 1'b1;
        step();
    endtask

    task automatic t_zero_wait();
        wait_cycles = 0;
        fill(CDP5);
        chk("R2 owned CDP absent", cop_absent, 0);
        chk("R3 zero wait busy", cop_busy, 0);
        cop_req_n = 1'b0;
        step();
        chk("R4 accept", accept_stb, 1);
        chk("R4 word", accept_word, CDP5);
        cop_req_n = 1'b1;
        step();
        chk("R4 one-cycle accept", accept_stb, 0);
    endtask

    task automatic t_order();
        wait_cycles = 0;
        push(LDC5); push(CDP5B); push(NOP);
        chk("R2 LDC owned", cop_absent, 0);
        cop_req_n = 1'b0;
        step();
        chk("R1 first word", accept_word, LDC5);
        cop_req_n = 1'b1;
        push(NOP);
        chk("R1 second present", cop_absent, 0);
        cop_req_n = 1'b0;
        step();
        chk("R1 second accept", accept_stb, 1);
        chk("R1 second word", accept_word, CDP5B);
        cop_req_n = 1'b1;
        step();
    endtask

    task automatic t_multi_wait();
        wait_cycles = 3;
        fill(CDP5);
        cop_req_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R3 busy during wait", cop_busy, 1);
            step();
        end
        chk("R3 busy released", cop_busy, 0);
        chk("R3 no early accept", accept_stb, 0);
        step();
        chk("R4 accept after wait", accept_stb, 1);
        chk("R4 word after wait", accept_word, CDP5);
        step();
        chk("R10 no second accept", accept_stb, 0);
        step();
        chk("R10 still none", accept_stb, 0);
        chk("R10 busy low", cop_busy, 0);
        cop_req_n = 1'b1;
        step();
        chk("R10 no abandon after commit", abandon_stb, 0);
    endtask

    task automatic t_strobe_idle();
        wait_cycles = 2;
        fill(CDP5);
        repeat (3) begin
            step();
            chk("R8 busy held", cop_busy, 1);
            chk("R8 no abandon", abandon_stb, 0);
            chk("R8 no accept", accept_stb, 0);
        end
        cop_req_n = 1'b0;
        chk("R8 count intact 1", cop_busy, 1);
        step();
        chk("R8 count intact 2", cop_busy, 1);
        step();
        chk("R8 busy released", cop_busy, 0);
        step();
        chk("R8 accept", accept_stb, 1);
        cop_req_n = 1'b1;
        step();
    endtask

    task automatic t_abandon();
        wait_cycles = 5;
        fill(CDP5);
        cop_req_n = 1'b0;
        step(); step();
        chk("R5 still busy", cop_busy, 1);
        cop_req_n = 1'b1;
        step();
        exp_count++;
        chk("R5 abandon", abandon_stb, 1);
        chk("R5 no accept", accept_stb, 0);
        chk("R5 count", abandon_count, exp_count);
        step();
        chk("R5 one-cycle abandon", abandon_stb, 0);
        chk("R5 busy dropped", cop_busy, 0);
        wait_cycles = 1;
        fill(CDP5B);
        cop_req_n = 1'b0;
        chk("R6 busy", cop_busy, 1);
        step();
        chk("R6 released", cop_busy, 0);
        step();
        chk("R6 accept", accept_stb, 1);
        chk("R6 word", accept_word, CDP5B);
        cop_req_n = 1'b1;
        step();
    endtask

    task automatic t_no_match();
        wait_cycles = 2;
        fill(CDP3);
        chk("R2 wrong unit absent", cop_absent, 1);
        chk("R11 no busy", cop_busy, 0);
        cop_req_n = 1'b0;
        repeat (3) begin
            step();
            chk("R11 no accept", accept_stb, 0);
        end
        cop_req_n = 1'b1;
        step();
        chk("R11 no abandon", abandon_stb, 0);
        chk("R11 count", abandon_count, exp_count);
        fill(ADD5);
        chk("R2 non-cop class absent", cop_absent, 1);
    endtask

    task automatic t_concurrent();
        wait_cycles = 4;
        fill(CDP5);
        cop_req_n = 1'b0;
        step();
        chk("R9 busy before", cop_busy, 1);
        cop_req_n   = 1'b1;
        wait_cycles = 0;
        push(LDC5);
        exp_count++;
        chk("R9 abandon with fetch", abandon_stb, 1);
        chk("R9 count", abandon_count, exp_count);
        chk("R9 shifted execute not owned", cop_absent, 1);
        push(NOP); push(NOP);
        chk("R9 fetched word present", cop_absent, 0);
        chk("R9 no wait", cop_busy, 0);
        cop_req_n = 1'b0;
        step();
        chk("R9 accept", accept_stb, 1);
        chk("R9 word", accept_word, LDC5);
        cop_req_n = 1'b1;
        step();
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step();
        t_reset();
        t_zero_wait();
        t_order();
        t_multi_wait();
        t_strobe_idle();
        t_abandon();
        t_no_match();
        t_concurrent();
        finish_run();
    end

endmodule